// File: doc/BRIEF.md
# Multiplexed Bus Controller with Dynamic Port Sizing

This block connects a 32-bit core request port to a synchronous external bus on which address and data share one set of lines. The core hands over one request at a time (byte, word, long word or a whole 16-byte line), and the block runs it on the bus. Each request starts with an address phase and is followed by a data phase that lasts until the device acknowledges it or signals a transfer error.

The device reports its port width (8, 16 or 32 bits) with each acknowledge. A single access to a narrow port is therefore split into as many bus cycles as that width requires. Each follow-on cycle gets its own address phase with the address moved on by the bytes already transferred. Write bytes are replicated across the byte lanes so that a port of any width finds its data. Read bytes are collected from the port's lanes into a 32-bit holding register, and only the complete result goes back to the core.

A line request becomes one four-beat burst. It has a single address phase, and the long-word index wraps inside the aligned line, starting at the requested word. Requests must be naturally aligned.

Top module: `mbus_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. Every accepted request gets exactly one response flagged `rsp_last`, and `req_ready` is high again in that same cycle.
- R2: One cycle after acceptance, `bus_ts` is high for one cycle. In that cycle `bus_ad` carries the address, `bus_rnw` is 1 for a read, and `bus_siz` carries the size code (00 long word, 01 byte, 10 word, 11 line). The data phase then holds until `bus_ack` or `bus_tea` is sampled high.
- R3: `bus_pw` is sampled with `bus_ack` and gives the port width: 00 = 32 bits, 01 = 8 bits, 10 = 16 bits, 11 = 32 bits. One bus cycle moves min(P - (A mod P), remaining bytes), where P is the port width in bytes and A is the current address. A long word therefore takes 1, 2 or 4 cycles on a 32-, 16- or 8-bit port.
- R4: Each follow-on cycle of a split access starts a new address phase at the previous address plus the bytes moved. Its `bus_siz` encodes the bytes still due: 1 gives byte, 2 gives word, 3 or 4 gives long word.
- R5: Byte lane k is `bus_ad[31-8k:24-8k]`, and address A maps to lane A mod 4 of a long word. In a write data phase, with R bytes remaining at address A, the bus carries the following. For R = 1 or R = 3, the byte for A is on all four lanes. For R = 2, the halfword for A is on both halves. For R = 4, the long word is on its natural lanes.
- R6: A read device returns the byte for address A on lane A mod P. The block places it in lane A mod 4 of `rsp_data`. Lanes outside the requested bytes read as zero. The response comes one cycle after the final acknowledge.
- R7: A line read has one address phase with `bus_siz` = 11 and the requested word's address, then four acknowledges. Each acknowledge yields a response one cycle later, with the beat's data and `rsp_word` = (start word + beat) mod 4. Only the fourth response has `rsp_last` set. `bus_pw` has no effect on a line.
- R8: During a line write, `beat_idx` shows the wrapped word index of the current beat. The `req_wdata` presented for it is driven onto the bus in the data phase.
- R9: `bus_tea` sampled high in a data phase ends the request at once. It abandons the remaining cycles or beats, and no data is written for that cycle. One cycle later a response appears with `rsp_err` and `rsp_last`, and no further address phase follows.
- R10: After reset `req_ready` is 1, and `bus_ts` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | Size code (00 long, 01 byte, 10 word, 11 line) |
| req_addr | input | ADDR_W | Aligned byte address |
| req_wdata | input | DATA_W | Write data, natural lanes; per beat for line writes |
| beat_idx | output | BEAT_W | Word index of the current line beat |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Request ended by transfer error |
| rsp_last | output | 1 | Final response of the request |
| rsp_word | output | BEAT_W | Word index of a line beat response |
| rsp_data | output | DATA_W | Read data, zero for writes |
| bus_ts | output | 1 | Address phase strobe |
| bus_rnw | output | 1 | 1 = read cycle |
| bus_siz | output | 2 | Size code of the bus cycle |
| bus_ad | output | DATA_W | Multiplexed address/write data |
| bus_ad_in | input | DATA_W | Read data from the device |
| bus_pw | input | 2 | Port width reported by the device |
| bus_ack | input | 1 | Data phase acknowledge |
| bus_tea | input | 1 | Transfer error acknowledge |

## Verification
A wrong remaining-byte count or a wrong address step shows up in the next address phase, one cycle after the acknowledge, as a wrong `bus_ad` or `bus_siz`, or as an extra or missing `bus_ts`. A wrong lane choice shows up within the same request. On a write it lands in the device's storage, which the bench compares after each request. On a read it appears in `rsp_data` one cycle after the last acknowledge. The sweeps cover every aligned offset of every size against every width code, and the error and line-wrap cases, so any of these faults shows up in the request that exercises it.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } mbc_state_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  localparam logic [1:0] PW_8  = 2'b01;
  localparam logic [1:0] PW_16 = 2'b10;

  // byte count of a request size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // size code announced for a number of bytes still due
  function automatic logic [1:0] size_of_rem(input logic [2:0] rem);
    case (rem)
      3'd1:    size_of_rem = SZ_BYTE;
      3'd2:    size_of_rem = SZ_WORD;
      default: size_of_rem = SZ_LONG;
    endcase
  endfunction

  // port width in bytes from the width code
  function automatic logic [2:0] port_bytes(input logic [1:0] pw);
    case (pw)
      PW_8:    port_bytes = 3'd1;
      PW_16:   port_bytes = 3'd2;
      default: port_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/mbc_step.sv
module mbc_step
  import mbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [$clog2(DATA_W/8):0]   rem,
  input  logic [1:0]                  pw,
  output logic [$clog2(DATA_W/8):0]   cnt
);
  localparam int OFF_W = $clog2(DATA_W/8);
  localparam int REM_W = OFF_W + 1;

  logic [REM_W-1:0] pb;
  logic [REM_W-1:0] pb_mask;
  logic [REM_W-1:0] room;

  assign pb      = REM_W'(port_bytes(pw));
  assign pb_mask = pb - REM_W'(1);
  assign room    = pb - ({1'b0, off} & pb_mask);
  assign cnt     = (room < rem) ? room : rem;

endmodule

// File: rtl/mbc_wr_steer.sv
module mbc_wr_steer #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           hold,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [$clog2(DATA_W/8):0]   rem,
  output logic [DATA_W-1:0]           drive
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int REM_W = OFF_W + 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFF_W-1:0] src;
    // full word: natural lane; halfword: replicated pair; odd count: one byte everywhere
    assign src = (rem == REM_W'(LANES)) ? OFF_W'(k) :
                 (rem == REM_W'(2))     ? (off | OFF_W'(k % 2)) :
                                          off;
    assign drive[DATA_W-1-8*k -: 8] = hold[DATA_W-1-8*int'(src) -: 8];
  end

endmodule

// File: rtl/mbc_rd_merge.sv
module mbc_rd_merge
  import mbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           hold,
  input  logic [DATA_W-1:0]           bus_in,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [$clog2(DATA_W/8):0]   cnt,
  input  logic [1:0]                  pw,
  output logic [DATA_W-1:0]           merged
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int REM_W = OFF_W + 1;

  logic [REM_W-1:0] lo;
  logic [REM_W-1:0] hi;
  assign lo = {1'b0, off};
  assign hi = lo + cnt;

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic             take;
    logic [OFF_W-1:0] src;
    assign take = (REM_W'(i) >= lo) && (REM_W'(i) < hi);
    assign src  = (pw == PW_8)  ? OFF_W'(0) :
                  (pw == PW_16) ? OFF_W'(i % 2) :
                                  OFF_W'(i);
    assign merged[DATA_W-1-8*i -: 8] = take ? bus_in[DATA_W-1-8*int'(src) -: 8]
                                            : hold[DATA_W-1-8*i -: 8];
  end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic [$clog2(LINE_BEATS)-1:0] beat_idx,
  output logic                          rsp_valid,
  output logic                          rsp_err,
  output logic                          rsp_last,
  output logic [$clog2(LINE_BEATS)-1:0] rsp_word,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          bus_ts,
  output logic                          bus_rnw,
  output logic [1:0]                    bus_siz,
  output logic [DATA_W-1:0]             bus_ad,
  input  logic [DATA_W-1:0]             bus_ad_in,
  input  logic [1:0]                    bus_pw,
  input  logic                          bus_ack,
  input  logic                          bus_tea
);
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int REM_W  = OFF_W + 1;
  localparam int BEAT_W = $clog2(LINE_BEATS);

  // state registers
  mbc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              wr_q, line_q;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              ctx_en, beat_en;

  logic              rsp_valid_q, rsp_err_q, rsp_last_q;
  logic [BEAT_W-1:0] rsp_word_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_d, rsp_last_d;
  logic [DATA_W-1:0] rsp_data_d;

  // event decode
  logic              accept, in_data, fin_err, beat_ok, step_ok, line_ok;
  logic              last_step, last_beat, rsp_fire;
  logic [REM_W-1:0]  cnt, rem_after;
  logic [OFF_W-1:0]  off;
  logic [BEAT_W-1:0] word_idx;
  logic [DATA_W-1:0] merged, steer;

  assign off      = addr_q[OFF_W-1:0];
  assign word_idx = addr_q[OFF_W +: BEAT_W] + beat_q;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign in_data   = (state_q == ST_DATA);
  assign fin_err   = in_data && bus_tea;
  assign beat_ok   = in_data && !bus_tea && bus_ack;
  assign step_ok   = beat_ok && !line_q;
  assign line_ok   = beat_ok && line_q;
  assign rem_after = rem_q - cnt;
  assign last_step = step_ok && (rem_after == '0);
  assign last_beat = line_ok && (beat_q == BEAT_W'(LINE_BEATS - 1));
  assign rsp_fire  = fin_err || line_ok || last_step;

  mbc_step #(.DATA_W(DATA_W)) u_step (
    .off (off),
    .rem (rem_q),
    .pw  (bus_pw),
    .cnt (cnt)
  );

  mbc_rd_merge #(.DATA_W(DATA_W)) u_merge (
    .hold   (hold_q),
    .bus_in (bus_ad_in),
    .off    (off),
    .cnt    (cnt),
    .pw     (bus_pw),
    .merged (merged)
  );

  mbc_wr_steer #(.DATA_W(DATA_W)) u_steer (
    .hold  (hold_q),
    .off   (off),
    .rem   (rem_q),
    .drive (steer)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (fin_err || last_step || last_beat) state_d = ST_IDLE;
        else if (step_ok)                      state_d = ST_ADDR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // access context: loaded on accept, advanced on each narrow cycle
  always_comb begin
    ctx_en = accept || step_ok;
    if (accept) begin
      addr_d = req_addr;
      rem_d  = REM_W'(size_bytes(req_size));
      hold_d = req_write ? req_wdata : '0;
    end else begin
      addr_d = addr_q + ADDR_W'(cnt);
      rem_d  = rem_after;
      hold_d = wr_q ? hold_q : merged;
    end
    beat_en = accept || line_ok;
    beat_d  = accept ? '0 : beat_q + BEAT_W'(1);
  end

  // response contents
  always_comb begin
    rsp_err_d  = fin_err;
    rsp_last_d = fin_err || last_step || last_beat;
    if (fin_err || wr_q) rsp_data_d = '0;
    else if (line_q)     rsp_data_d = bus_ad_in;
    else                 rsp_data_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
      line_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ctx_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        hold_q <= hold_d;
      end
      if (accept) begin
        wr_q   <= req_write;
        line_q <= (req_size == SZ_LINE);
      end
      if (beat_en) beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_word_q  <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_fire;
      if (rsp_fire) begin
        rsp_err_q  <= rsp_err_d;
        rsp_last_q <= rsp_last_d;
        rsp_word_q <= word_idx;
        rsp_data_q <= rsp_data_d;
      end
    end
  end

  // outputs
  assign req_ready = (state_q == ST_IDLE);
  assign beat_idx  = word_idx;
  assign bus_ts    = (state_q == ST_ADDR);
  assign bus_rnw   = !wr_q;
  assign bus_siz   = line_q ? SZ_LINE : size_of_rem(rem_q);
  assign bus_ad    = (state_q == ST_ADDR)  ? DATA_W'(addr_q) :
                     (in_data && wr_q)     ? (line_q ? req_wdata : steer) :
                                             '0;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_last  = rsp_last_q;
  assign rsp_word  = rsp_word_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/mbc_chk.sv
module mbc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic rsp_last,
  input logic bus_ts,
  input logic bus_tea
);

  // R2
  ts_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);

  // R1
  busy_during_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |-> !req_ready);

  // R1
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> req_ready);

  // R9
  err_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_last);

  // R9
  tea_ends_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_ts && bus_tea) |=> (rsp_valid && rsp_err));

  // R7
  burst_no_readdress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> !bus_ts);

endmodule

bind mbus_ctrl mbc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_last  (rsp_last),
  .bus_ts    (bus_ts),
  .bus_tea   (bus_tea)
);

// File: tb/mbus_ctrl_tb.sv
module mbus_ctrl_tb;

  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  beat_idx, rsp_word;
  logic        rsp_valid, rsp_err, rsp_last;
  logic [31:0] rsp_data;
  logic        bus_ts, bus_rnw;
  logic [1:0]  bus_siz, bus_pw;
  logic [31:0] bus_ad, bus_ad_in;
  logic        bus_ack, bus_tea;

  mbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .beat_idx(beat_idx), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_last(rsp_last), .rsp_word(rsp_word), .rsp_data(rsp_data),
    .bus_ts(bus_ts), .bus_rnw(bus_rnw), .bus_siz(bus_siz), .bus_ad(bus_ad),
    .bus_ad_in(bus_ad_in), .bus_pw(bus_pw), .bus_ack(bus_ack), .bus_tea(bus_tea)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit all_done = 0;

  // device storage and independent expectation
  logic [7:0]  mem  [64];
  logic [7:0]  emem [64];
  logic [31:0] lw   [4];
  logic [31:0] sw_data;
  bit          line_wr;

  assign req_wdata = line_wr ? lw[beat_idx] : sw_data;

  // device configuration and log
  int          cfg_wait, cfg_err, dcnt;
  logic [1:0]  cfg_pw;
  int          ts_n;
  logic [31:0] ts_addr [8];
  logic [1:0]  ts_siz  [8];

  // collected responses
  int          rn;
  logic [31:0] r_data [8];
  logic [1:0]  r_word [8];
  logic        r_err  [8];
  logic        r_last [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int pbytes(input logic [1:0] pw);
    return (pw == 2'b01) ? 1 : (pw == 2'b10) ? 2 : 4;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
  endfunction

  // device responder, acts at falling edges
  initial begin
    logic [31:0] ra;
    logic [1:0]  rs;
    bit          rrd, in_data;
    int          wcnt, rbeat;
    bus_ack = 0; bus_tea = 0; bus_ad_in = '0; bus_pw = 2'b00;
    in_data = 0; wcnt = 0; rbeat = 0; ra = '0; rs = '0; rrd = 0;
    forever begin
      @(negedge clk);
      bus_ack = 0; bus_tea = 0;
      bus_pw = cfg_pw;
      if (!rst_n) begin
        in_data = 0;
      end else if (bus_ts) begin
        ra = bus_ad; rs = bus_siz; rrd = bus_rnw; rbeat = 0;
        wcnt = cfg_wait; in_data = 1;
        if (ts_n < 8) begin ts_addr[ts_n] = bus_ad; ts_siz[ts_n] = bus_siz; end
        ts_n++;
      end else if (in_data) begin
        if (wcnt > 0) wcnt--;
        else begin
          dcnt++;
          if (dcnt == cfg_err) begin
            bus_tea = 1; in_data = 0;
          end else begin
            bus_ack = 1;
            if (rs == 2'b11) begin
              int base;
              base = int'(ra[5:4]) * 16 + ((int'(ra[3:2]) + rbeat) % 4) * 4;
              if (rrd) bus_ad_in = {mem[base], mem[base+1], mem[base+2], mem[base+3]};
              else for (int j = 0; j < 4; j++) mem[base+j] = bus_ad[31-8*j -: 8];
              rbeat++;
              if (rbeat == 4) in_data = 0; else wcnt = cfg_wait;
            end else begin
              int pb, a, c;
              pb = pbytes(cfg_pw);
              a  = int'(ra[5:0]);
              c  = pb - (a % pb);
              if (nbytes(rs) < c) c = nbytes(rs);
              bus_ad_in = 32'hA5A5_A5A5;
              for (int j = 0; j < c; j++) begin
                if (rrd) bus_ad_in[31-8*((a+j)%pb) -: 8] = mem[a+j];
                else     mem[a+j] = bus_ad[31-8*((a+j)%pb) -: 8];
              end
              in_data = 0;
            end
          end
        end
      end
    end
  end

  task automatic run(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [1:0] pw, input int wt, input int err_at);
    cfg_pw = pw; cfg_wait = wt; cfg_err = err_at; dcnt = 0; ts_n = 0; rn = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 80; t++) begin
      @(negedge clk);
      if (rsp_valid) begin
        r_data[rn] = rsp_data; r_word[rn] = rsp_word;
        r_err[rn] = rsp_err; r_last[rn] = rsp_last;
        rn++;
        if (rsp_last || rn == 8) break;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < 64; i++) if (bad < 0 && mem[i] !== emem[i]) bad = i;
    chk(bad < 0, tag, (bad < 0) ? 32'h0 : {24'h0, mem[bad]},
        (bad < 0) ? 32'h0 : {24'h0, emem[bad]});
  endtask

  task automatic single(input bit wr, input logic [1:0] sz, input int a,
                        input logic [1:0] pw, input int wt);
    int pb, n, cur, rem, k;
    logic [31:0] exp;
    pb = pbytes(pw); n = nbytes(sz);
    sw_data = {8'(a*3+1), 8'(a*5+7), 8'(a+90), 8'(a^8'h5C)} ^ {30'h0, pw};
    run(wr, sz, BASE + 32'(a), pw, wt, 0);
    chk(rn == 1 && r_last[0] === 1'b1 && r_err[0] === 1'b0, "R1 one final response", 32'(rn), 32'd1);
    // expected address phases
    cur = a; rem = n; k = 0;
    while (rem > 0) begin
      int c;
      logic [1:0] es;
      c = pb - (cur % pb);
      if (rem < c) c = rem;
      es = (rem == 1) ? 2'b01 : (rem == 2) ? 2'b10 : 2'b00;
      if (k < 8) begin
        chk(ts_addr[k] === BASE + 32'(cur), "R4 follow-on address", ts_addr[k], BASE + 32'(cur));
        chk(ts_siz[k] === es, "R4 size of remaining", {30'h0, ts_siz[k]}, {30'h0, es});
      end
      cur += c; rem -= c; k++;
    end
    chk(ts_n == k, "R3 bus cycle count for width", 32'(ts_n), 32'(k));
    if (!wr) begin
      exp = '0;
      for (int j = 0; j < n; j++) exp[31-8*((a+j)%4) -: 8] = emem[a+j];
      chk(r_data[0] === exp, "R6 merged read data", r_data[0], exp);
    end else begin
      for (int j = 0; j < n; j++) emem[a+j] = sw_data[31-8*((a+j)%4) -: 8];
      mem_cmp("R5 write lanes");
    end
  endtask

  initial begin
    all_done = 0;
    for (int i = 0; i < 64; i++) begin mem[i] = 8'(i*7+3); emem[i] = 8'(i*7+3); end
    for (int i = 0; i < 4; i++) lw[i] = '0;
    line_wr = 0; sw_data = '0;
    cfg_pw = 2'b00; cfg_wait = 0; cfg_err = 0; dcnt = 0; ts_n = 0; rn = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_size = 2'b00; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R10
    chk(req_ready === 1'b1 && bus_ts === 1'b0 && rsp_valid === 1'b0, "R10 reset state",
        {29'h0, req_ready, bus_ts, rsp_valid}, 32'h4);

    // sweep: every width code, size and aligned offset, read and write (R3 R4 R5 R6)
    for (int pw = 0; pw < 4; pw++)
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 3; sz++) begin
          int step;
          step = nbytes(2'(sz));
          for (int o = 0; o < 4; o += step)
            single(wr[0], 2'(sz), 16 + pw*8 + ((sz == 0) ? 0 : 4) + o - ((sz == 0) ? 0 : 4),
                   2'(pw), (o + sz) % 2);
        end

    // line reads, every starting word (R7), width input set narrow to show it has no effect
    for (int w0 = 0; w0 < 4; w0++) begin
      run(1'b0, 2'b11, BASE + 32'h20 + 32'(w0*4), 2'b01, w0 % 2, 0);
      chk(ts_n == 1 && ts_siz[0] === 2'b11 && ts_addr[0] === BASE + 32'h20 + 32'(w0*4),
          "R7 single line address phase", ts_addr[0], BASE + 32'h20 + 32'(w0*4));
      chk(rn == 4, "R7 four beat responses", 32'(rn), 32'd4);
      for (int b = 0; b < 4 && b < rn; b++) begin
        int w, base;
        logic [31:0] exp;
        w = (w0 + b) % 4; base = 32 + w*4;
        exp = {emem[base], emem[base+1], emem[base+2], emem[base+3]};
        chk(r_word[b] === 2'(w) && r_data[b] === exp, "R7 wrapped beat data", r_data[b], exp);
        chk(r_last[b] === (b == 3), "R7 last flag", {31'h0, r_last[b]}, {31'h0, b == 3});
      end
    end

    // line writes (R8)
    for (int w0 = 0; w0 < 4; w0++) begin
      for (int i = 0; i < 4; i++) lw[i] = {8'(w0*16+i), 8'hC3, 8'(i*9), 8'(w0+i+1)};
      line_wr = 1;
      run(1'b1, 2'b11, BASE + 32'h30 + 32'(w0*4), 2'b10, (w0 + 1) % 2, 0);
      line_wr = 0;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) emem[48 + i*4 + j] = lw[i][31-8*j -: 8];
      chk(rn == 4 && r_last[3] === 1'b1, "R8 line write responses", 32'(rn), 32'd4);
      mem_cmp("R8 line write storage");
    end

    // error in the second cycle of a long read on an 8-bit port (R9)
    run(1'b0, 2'b00, BASE + 32'h04, 2'b01, 0, 2);
    chk(rn == 1 && r_err[0] === 1'b1 && r_last[0] === 1'b1, "R9 error response",
        {30'h0, r_err[0], r_last[0]}, 32'h3);
    chk(ts_n == 2, "R9 no address phase after error", 32'(ts_n), 32'd2);
    // error on the third beat of a line read (R9)
    run(1'b0, 2'b11, BASE + 32'h08, 2'b00, 1, 3);
    chk(rn == 3 && r_err[2] === 1'b1 && r_last[2] === 1'b1 && r_err[0] === 1'b0 && r_last[1] === 1'b0,
        "R9 burst abandoned", 32'(rn), 32'd3);
    chk(r_data[0] === {emem[8], emem[9], emem[10], emem[11]}, "R9 beats before error",
        r_data[0], {emem[8], emem[9], emem[10], emem[11]});
    // error on the first cycle of a write: storage untouched (R9)
    sw_data = 32'hDEAD_BEEF;
    run(1'b1, 2'b00, BASE + 32'h0C, 2'b10, 0, 1);
    chk(rn == 1 && r_err[0] === 1'b1 && ts_n == 1, "R9 write error", 32'(ts_n), 32'd1);
    mem_cmp("R9 write abandoned");
    // recovery after errors (R1)
    single(1'b0, 2'b00, 12, 2'b10, 1);

    all_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule